// File: doc/BRIEF.md
# Clustered Message Router with Inter-Cluster Gateways

This block moves short messages among sixteen processing nodes. The nodes form four clusters of four. Each cluster owns a bus. A node offers a message on a valid/ready handshake. The message is a data word and a 4-bit destination node ID. When the destination sits in the sender's own cluster, the message crosses that cluster's bus and reaches the receiver on the next clock edge. No other cluster is involved.

When the destination lies in another cluster, the sender's own cluster bus hands the message to that cluster's gateway. The gateway queues it in a small outbound buffer, and the sender is released at that moment. One shared inter-cluster link takes turns among the gateways. It carries one queued message per cycle into the inbound buffer of the target cluster's gateway. That gateway then competes for its own bus and delivers the message to the addressed node.

Receivers always accept, so delivery is a one-cycle registered pulse on the receiver's output. The pulse carries the data and the sender's ID.

Top module: `cluster_router`

## Requirements
- R1: While reset is high, and on the first cycle after it, every out_valid bit is 0. With no in_valid asserted, every in_ready bit is 0.
- R2: A message accepted from node S for node D in the same cluster raises out_valid[D] one cycle after acceptance. out_data[D] then carries the message data and out_src[D] carries S.
- R3: Each cluster bus grants at most one transfer per cycle. Lower node index within the cluster wins. The gateway delivery port has the lowest priority. in_ready is only ever high together with in_valid.
- R4: Transfers that stay inside different clusters are accepted in the same cycle and delivered together.
- R5: With no contention, a message for another cluster reaches out_valid of its destination three cycles after acceptance.
- R6: Each gateway's outbound buffer holds 2 messages and its inbound buffer holds 2. A node with a remote destination is not given in_ready while its gateway's outbound buffer is full. Local transfers on that bus still proceed.
- R7: The inter-cluster link moves at most one message per cycle. It serves the gateways round-robin, and gateway 0 is served first after reset.
- R8: A destination ID uses bits [3:2] as the cluster number and bits [1:0] as the node within the cluster. Node n belongs to cluster n/4.
- R9: A sender with a remote destination is released (in_ready high) in the cycle its gateway accepts the message, before delivery takes place.
- R10: Messages from one sender to one remote receiver arrive in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 16 | Per-node message offer |
| in_ready | output | 16 | Per-node acceptance, high in the accepting cycle |
| in_dest | input | 64 | Per-node 4-bit destination ID, node n at [4n+3:4n] |
| in_data | input | 256 | Per-node 16-bit payload, node n at [16n+15:16n] |
| out_valid | output | 16 | Per-node delivery pulse |
| out_src | output | 64 | Sender ID of the delivered message, per node |
| out_data | output | 256 | Payload of the delivered message, per node |

## Verification
Several properties are checked on every cycle: the one-grant-per-bus rule, ready never appearing without valid, correct local delivery of data and sender, no remote acceptance into a full outbound buffer, the single-grant link, and the reset quiet state. Other behaviours depend on a whole sequence of cycles, and only the bench scenarios can show them. These are the three-cycle remote latency, the round-robin order of the link, the exact count of messages absorbed before backpressure reaches a sender when the target bus is kept busy, and the in-order arrival of those messages once the bus frees up.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int DEF_CLUSTERS = 4;
  localparam int DEF_NODES_PER_CLUSTER = 4;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_BUF_DEPTH = 2;

  function automatic int unsigned bits_for(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gw_fifo.sv
module gw_fifo #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             valid,
  output logic             full
);
  localparam int AW = router_pkg::bits_for(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rdata = mem[rd_ptr];
  assign valid = (count != '0);
  assign full  = (int'(count) == DEPTH);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = router_pkg::bits_for(N);

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          hit;

  always_comb begin
    gnt = '0;
    hit = 1'b0;
    win = '0;
    for (int off = 0; off < N; off++) begin
      if (!hit && req[(int'(ptr) + off) % N]) begin
        hit = 1'b1;
        gnt[(int'(ptr) + off) % N] = 1'b1;
        win = PW'((int'(ptr) + off) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (hit) ptr <= PW'((int'(win) + 1) % N);
  end
endmodule

// File: rtl/cluster_router.sv
module cluster_router #(
  parameter int NUM_CLUSTERS      = router_pkg::DEF_CLUSTERS,
  parameter int NODES_PER_CLUSTER = router_pkg::DEF_NODES_PER_CLUSTER,
  parameter int DATA_W            = router_pkg::DEF_DATA_W,
  parameter int BUF_DEPTH         = router_pkg::DEF_BUF_DEPTH,
  localparam int NODES = NUM_CLUSTERS * NODES_PER_CLUSTER,
  localparam int ID_W  = router_pkg::bits_for(NODES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NODES-1:0]        in_valid,
  output logic [NODES-1:0]        in_ready,
  input  logic [NODES*ID_W-1:0]   in_dest,
  input  logic [NODES*DATA_W-1:0] in_data,
  output logic [NODES-1:0]        out_valid,
  output logic [NODES*ID_W-1:0]   out_src,
  output logic [NODES*DATA_W-1:0] out_data
);
  localparam int NPC   = NODES_PER_CLUSTER;
  localparam int CL_W  = router_pkg::bits_for(NUM_CLUSTERS);
  localparam int LN_W  = router_pkg::bits_for(NPC);
  localparam int MSG_W = 2 * ID_W + DATA_W;
  localparam int DST_LO = DATA_W;
  localparam int SRC_LO = DATA_W + ID_W;

  logic [NUM_CLUSTERS-1:0] ob_push, ob_valid, ob_full;
  logic [NUM_CLUSTERS-1:0] ib_push, ib_pop, ib_valid, ib_full;
  logic [NUM_CLUSTERS-1:0] link_req, link_grant;
  logic [MSG_W-1:0]        ob_in   [NUM_CLUSTERS];
  logic [MSG_W-1:0]        ob_head [NUM_CLUSTERS];
  logic [MSG_W-1:0]        ib_head [NUM_CLUSTERS];
  logic [CL_W-1:0]         ob_tgt  [NUM_CLUSTERS];
  logic [MSG_W-1:0]        link_msg;
  logic [CL_W-1:0]         link_tgt;
  logic                    link_fire;

  // shared inter-cluster link
  rr_arbiter #(.N(NUM_CLUSTERS)) u_link_arb (
    .clk(clk), .rst(rst), .req(link_req), .gnt(link_grant)
  );

  always_comb begin
    link_msg = ob_head[0];
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      if (link_grant[c]) link_msg = ob_head[c];
    end
  end

  assign link_fire = |link_grant;
  assign link_tgt  = link_msg[DST_LO+ID_W-1 -: CL_W];

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cl
    logic [NPC:0]       req, gnt;
    logic [NPC-1:0]     node_local;
    logic [MSG_W-1:0]   node_msg [NPC];
    logic [MSG_W-1:0]   win_msg;
    logic               win_local;
    logic               deliver;
    logic [LN_W-1:0]    win_node;
    logic [NPC-1:0]     ov;
    logic [ID_W-1:0]    osrc [NPC];
    logic [DATA_W-1:0]  odat [NPC];

    for (genvar k = 0; k < NPC; k++) begin : g_nd
      localparam int S = c * NPC + k;
      logic [ID_W-1:0] d;
      assign d             = in_dest[S*ID_W +: ID_W];
      assign node_local[k] = (d[ID_W-1 -: CL_W] == CL_W'(c));
      assign req[k]        = in_valid[S] && (node_local[k] || !ob_full[c]);
      assign node_msg[k]   = {ID_W'(S), d, in_data[S*DATA_W +: DATA_W]};
      assign in_ready[S]   = gnt[k];
      assign out_valid[S]  = ov[k];
      assign out_src[S*ID_W +: ID_W]     = osrc[k];
      assign out_data[S*DATA_W +: DATA_W] = odat[k];
    end

    // gateway delivery port sits at the lowest priority
    assign req[NPC] = ib_valid[c];

    bus_arbiter #(.N(NPC + 1)) u_bus_arb (.req(req), .gnt(gnt));

    always_comb begin
      win_msg   = ib_head[c];
      win_local = 1'b1;
      for (int k = 0; k < NPC; k++) begin
        if (gnt[k]) begin
          win_msg   = node_msg[k];
          win_local = node_local[k];
        end
      end
    end

    assign deliver    = (|gnt) && win_local;
    assign win_node   = win_msg[DST_LO +: LN_W];
    assign ob_push[c] = (|gnt[NPC-1:0]) && !win_local;
    assign ob_in[c]   = win_msg;
    assign ib_pop[c]  = gnt[NPC];

    always_ff @(posedge clk) begin
      if (rst) begin
        ov <= '0;
      end else begin
        for (int k = 0; k < NPC; k++) begin
          ov[k] <= deliver && (win_node == LN_W'(k));
        end
      end
    end

    always_ff @(posedge clk) begin
      for (int k = 0; k < NPC; k++) begin
        if (deliver && (win_node == LN_W'(k))) begin
          osrc[k] <= win_msg[SRC_LO +: ID_W];
          odat[k] <= win_msg[DATA_W-1:0];
        end
      end
    end

    gw_fifo #(.WIDTH(MSG_W), .DEPTH(BUF_DEPTH)) u_outbound (
      .clk(clk), .rst(rst), .push(ob_push[c]), .wdata(ob_in[c]),
      .pop(link_grant[c]), .rdata(ob_head[c]), .valid(ob_valid[c]),
      .full(ob_full[c])
    );

    gw_fifo #(.WIDTH(MSG_W), .DEPTH(BUF_DEPTH)) u_inbound (
      .clk(clk), .rst(rst), .push(ib_push[c]), .wdata(link_msg),
      .pop(ib_pop[c]), .rdata(ib_head[c]), .valid(ib_valid[c]),
      .full(ib_full[c])
    );

    assign ob_tgt[c]   = ob_head[c][DST_LO+ID_W-1 -: CL_W];
    assign link_req[c] = ob_valid[c] && !ib_full[ob_tgt[c]];
    assign ib_push[c]  = link_fire && (link_tgt == CL_W'(c));
  end
endmodule

// File: rtl/router_checker.sv
module router_checker #(
  parameter int NUM_CLUSTERS      = 4,
  parameter int NODES_PER_CLUSTER = 4,
  parameter int DATA_W            = 16,
  localparam int NODES = NUM_CLUSTERS * NODES_PER_CLUSTER,
  localparam int ID_W  = router_pkg::bits_for(NODES),
  localparam int CL_W  = router_pkg::bits_for(NUM_CLUSTERS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NODES-1:0]        in_valid,
  input logic [NODES-1:0]        in_ready,
  input logic [NODES*ID_W-1:0]   in_dest,
  input logic [NODES-1:0]        out_valid,
  input logic [NODES*ID_W-1:0]   out_src,
  input logic [NUM_CLUSTERS-1:0] ob_full,
  input logic [NUM_CLUSTERS-1:0] link_grant
);
  localparam int NPC = NODES_PER_CLUSTER;

  p_quiet_r1: assert property (@(posedge clk) rst |=> (out_valid == '0))
    else $error("R1 out_valid not quiet after reset");

  p_link_single_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(link_grant))
    else $error("R7 link granted twice");

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_c
    p_one_grant_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(in_ready[c*NPC +: NPC]))
      else $error("R3 two grants on one bus");

    for (genvar k = 0; k < NPC; k++) begin : g_s
      localparam int S = c * NPC + k;
      logic [ID_W-1:0] d;
      assign d = in_dest[S*ID_W +: ID_W];

      p_ready_valid_r3: assert property (@(posedge clk) disable iff (rst)
        in_ready[S] |-> in_valid[S])
        else $error("R3 ready without valid");

      p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (ob_full[c] && in_valid[S] && (d[ID_W-1 -: CL_W] != CL_W'(c)))
          |-> !in_ready[S])
        else $error("R6 remote accept into full outbound buffer");

      for (genvar j = 0; j < NPC; j++) begin : g_d
        localparam int D = c * NPC + j;
        p_local_r2: assert property (@(posedge clk) disable iff (rst)
          (in_valid[S] && in_ready[S] && (d == ID_W'(D)))
            |=> (out_valid[D] && (out_src[D*ID_W +: ID_W] == ID_W'(S))))
          else $error("R2 local delivery missing");
      end
    end
  end
endmodule

bind cluster_router router_checker #(
  .NUM_CLUSTERS(NUM_CLUSTERS),
  .NODES_PER_CLUSTER(NODES_PER_CLUSTER),
  .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_dest(in_dest), .out_valid(out_valid), .out_src(out_src),
  .ob_full(ob_full), .link_grant(link_grant)
);

// File: tb/cluster_router_tb.sv
`timescale 1ns/1ps
module cluster_router_tb;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int DW = 16;
  localparam int NV = 8;
  // {src, dst, data}
  localparam logic [23:0] VEC [NV] = '{
    24'h01A101, 24'h56B202, 24'hFCC303, 24'h33D404,
    24'h07E505, 24'h6DF606, 24'hA21707, 24'hF02808
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [N*IW-1:0] in_dest = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    out_valid;
  logic [N*IW-1:0] out_src;
  logic [N*DW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cluster_router u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
    .out_src(out_src), .out_data(out_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int s, input int d, input logic [15:0] v);
    in_valid[s] = 1'b1;
    in_dest[s*IW +: IW] = IW'(d);
    in_data[s*DW +: DW] = v;
  endtask

  task automatic drop(input int s);
    in_valid[s] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int acc;
    int got;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "out_valid in reset", 32'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk("R1", "out_valid after reset", 32'(out_valid), 0);
    chk("R1", "in_ready idle", 32'(in_ready), 0);

    // table walk: R2/R8 local, R5/R9 remote
    for (int i = 0; i < NV; i++) begin
      int s, d;
      logic [15:0] v;
      s = int'(VEC[i][23:20]);
      d = int'(VEC[i][19:16]);
      v = VEC[i][15:0];
      @(negedge clk);
      put(s, d, v);
      #1;
      chk((s/4 == d/4) ? "R2" : "R9", "sender ready", 32'(in_ready[s]), 1);
      @(negedge clk);
      drop(s);
      if (s/4 != d/4) begin
        #1;
        chk("R5", "no early delivery", 32'(out_valid), 0);
        repeat (2) @(negedge clk);
      end
      #1;
      chk((s/4 == d/4) ? "R2" : "R5", "out_valid one-hot", 32'(out_valid), 32'(1) << d);
      chk("R8", "out_data", 32'(out_data[d*DW +: DW]), 32'(v));
      chk("R8", "out_src", 32'(out_src[d*IW +: IW]), 32'(s));
    end

    // R3 fixed priority
    @(negedge clk);
    put(0, 3, 16'h0A00); put(1, 3, 16'h0A01); put(2, 3, 16'h0A02);
    #1;
    chk("R3", "node0 first", 32'(in_ready), 32'h0001);
    @(negedge clk); drop(0); #1;
    chk("R3", "src after 1st", 32'(out_src[3*IW +: IW]), 0);
    chk("R3", "node1 next", 32'(in_ready), 32'h0002);
    @(negedge clk); drop(1); #1;
    chk("R3", "src after 2nd", 32'(out_src[3*IW +: IW]), 1);
    chk("R3", "node2 next", 32'(in_ready), 32'h0004);
    @(negedge clk); drop(2); #1;
    chk("R3", "src after 3rd", 32'(out_src[3*IW +: IW]), 2);

    // R4 clusters in parallel
    @(negedge clk);
    put(0, 1, 16'h4000); put(4, 5, 16'h4001); put(8, 9, 16'h4002); put(12, 13, 16'h4003);
    #1;
    chk("R4", "all four ready", 32'(in_ready), 32'h1111);
    @(negedge clk);
    drop(0); drop(4); drop(8); drop(12);
    #1;
    chk("R4", "four deliveries", 32'(out_valid), 32'h2222);

    // R7 round-robin on the link
    do_reset();
    put(0, 8, 16'h7000); put(4, 12, 16'h7001);
    #1;
    chk("R7", "both gateways accept", 32'(in_ready), 32'h0011);
    @(negedge clk); drop(0); drop(4);
    @(negedge clk);
    @(negedge clk); #1;
    chk("R7", "gateway0 first", 32'(out_valid), 32'h0100);
    @(negedge clk); #1;
    chk("R7", "gateway1 second", 32'(out_valid), 32'h1000);

    // R6 backpressure, R10 ordering
    do_reset();
    put(4, 5, 16'h5555);
    put(1, 2, 16'h1212);
    acc = 0;
    for (int cy = 0; cy < 8; cy++) begin
      if (cy != 0) @(negedge clk);
      put(0, 6, 16'hC000 + 16'(acc));
      #1;
      if (in_ready[0]) acc++;
    end
    chk("R6", "messages absorbed", 32'(acc), 4);
    chk("R6", "remote sender held", 32'(in_ready[0]), 0);
    chk("R6", "local still flows", 32'(in_ready[1]), 1);
    @(negedge clk);
    drop(0); drop(1); drop(4);
    got = 0;
    for (int cy = 0; cy < 10; cy++) begin
      @(negedge clk); #1;
      if (out_valid[6]) begin
        chk("R10", "order", 32'(out_data[6*DW +: DW]), 32'h0000C000 + 32'(got));
        got++;
      end
    end
    chk("R6", "all delivered", 32'(got), 4);

    done = 1'b1;
    summary();
  end
endmodule